// File: doc/BRIEF.md
# Peripheral Control Register Bank

This block holds sixty-four 16-bit control registers that sit behind a simple processor bus. Each clock, the bus can issue one write of a byte, a halfword or a word, and the bank reads one halfword by register index. Before a write is stored, the bank shapes it for the register it targets. It merges a byte into its halfword, keeps only the writable bits of masked registers, clears interrupt flags where ones are written, and joins the two halves of paired registers into a single 32-bit value. The live button vector is presented on a read-only port in inverted form.

Every accepted write produces a registered commit strobe one cycle later. The strobe carries the register index and the value that was stored, so that downstream engines (video, sound, transfer, timers) can pick up new settings without decoding the bus themselves. A byte write to a dedicated control address does not touch the store. Instead it raises a one-cycle halt or stop request for the processor core.

Top module: `io_bank`

## Requirements
- R1: After synchronous reset, register 0 reads 0x0080, register 2 reads 0x0200 and every other stored register reads 0. A read returns the register addressed by `rd_idx` one clock later.
- R2: A halfword write (`wr_size`=1) to a writable register stores the value. In the next cycle, and for that cycle only, it raises `commit_o` with `commit_idx` = byte address / 2, `commit_val` = stored value zero-extended, and `commit_wide`=0.
- R3: A byte write (`wr_size`=0) replaces the lane chosen by address bit 0 (1 = bits 15:8) with data bits 7:0. The other lane keeps its stored value, and the merged halfword is handled as in R2.
- R4: Register 1 keeps only bits under mask 0xFFF8. Registers 12 to 15 keep only bits under mask 0x00C7. Register 16 keeps only bits under mask 0xC1FF.
- R5: Register 25 holds interrupt flags. A write clears each bit where the data is 1 and leaves the other bits unchanged. A bit set on `irq_raise` is ORed in during the same cycle and wins over a clear. The commit value is the result after the clear.
- R6: Register 8 is write-only. Writes to it commit as in R2, but it always reads 0.
- R7: Registers 4/5 and 6/7 are 32-bit pairs, with the even index holding the low half. A byte, halfword or word write to either half builds {high, low} from the new data and the stored other half. It stores both halves and commits once with `commit_idx` = even index, `commit_wide`=1 and the full 32-bit value.
- R8: A word write (`wr_size`=2) to a non-paired location at byte address A (bits 1:0 ignored) is applied as two halfword writes to A and A+2. Both halves are stored together. The commit for A comes one cycle after the write and the commit for A+2 one cycle after that. The bus leaves the cycle after a word write idle.
- R9: Register 20 reads as 0x3FF XOR `keys`, where `keys` is active high. Writes to register 20 are ignored and produce no commit.
- R10: A byte write to byte address 61 raises `halt_o` for one cycle if data bit 7 is 0, or `stop_o` if bit 7 is 1. It changes no register and produces no commit.
- R11: Indices outside {0, 1, 2, 4 to 9, 12 to 16, 20, 24 to 26} ignore writes, produce no commit and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request this cycle |
| wr_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 no operation |
| wr_addr | input | 7 | Write byte address |
| wr_data | input | 32 | Write data, right-aligned |
| rd_idx | input | 6 | Halfword register index to read |
| rd_data | output | 16 | Registered read data |
| keys | input | 10 | Live button vector, 1 = pressed |
| irq_raise | input | 16 | Interrupt flag set requests |
| commit_o | output | 1 | One-cycle commit strobe |
| commit_idx | output | 6 | Index of the committed register |
| commit_val | output | 32 | Committed value (32-bit for pairs) |
| commit_wide | output | 1 | Commit is a joined 32-bit pair |
| halt_o | output | 1 | One-cycle halt request |
| stop_o | output | 1 | One-cycle stop request |

## Verification
Writes are driven at every width against plain, masked, flag, write-only, paired, read-only and undecoded registers. This separates lane merging, masking, clear-on-one handling and pair joining, since the same data pattern yields different stored values in each case. Word writes are aimed at both a paired location and a pair of masked timer registers, which tells the single joined commit apart from the two staggered ones. An interrupt raise is issued in the same cycle as a clear of the same bit to pin down which one wins. The halt address is hit with bit 7 both clear and set. Key reads use two button patterns so that the inversion cannot pass by chance.

// File: rtl/io_bank_pkg.sv
package io_bank_pkg;

  localparam int KEY_BITS   = 10;
  localparam int IX_DSP_CTL = 0;
  localparam int IX_DSP_STA = 1;
  localparam int IX_SND_BIA = 2;
  localparam int PAIR_BASE  = 4;
  localparam int N_PAIRS    = 2;
  localparam int IX_XFR_LEN = 8;
  localparam int IX_XFR_CTL = 9;
  localparam int TMR_BASE   = 12;
  localparam int N_TMR      = 4;
  localparam int IX_SER_MOD = 16;
  localparam int IX_KEYS    = 20;
  localparam int IX_IRQ_EN  = 24;
  localparam int IX_IRQ_FLG = 25;
  localparam int IX_IRQ_MST = 26;
  localparam int HALT_BYTE  = 61;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_NONE = 2'd3
  } acc_size_e;

  function automatic logic is_pair(input int ix);
    return (ix >= PAIR_BASE) && (ix < PAIR_BASE + 2 * N_PAIRS);
  endfunction

  function automatic logic is_tmr(input int ix);
    return (ix >= TMR_BASE) && (ix < TMR_BASE + N_TMR);
  endfunction

  // registers that accept writes (key port is read-only)
  function automatic logic wr_ok(input int ix);
    return (ix == IX_DSP_CTL) || (ix == IX_DSP_STA) || (ix == IX_SND_BIA) ||
           is_pair(ix) || (ix == IX_XFR_LEN) || (ix == IX_XFR_CTL) ||
           is_tmr(ix) || (ix == IX_SER_MOD) || (ix == IX_IRQ_EN) ||
           (ix == IX_IRQ_FLG) || (ix == IX_IRQ_MST);
  endfunction

  // registers whose stored value is visible on a read
  function automatic logic rd_ok(input int ix);
    return wr_ok(ix) && (ix != IX_XFR_LEN);
  endfunction

  function automatic logic [15:0] wmask(input int ix);
    if (ix == IX_DSP_STA) return 16'hFFF8;
    if (is_tmr(ix))       return 16'h00C7;
    if (ix == IX_SER_MOD) return 16'hC1FF;
    return 16'hFFFF;
  endfunction

  function automatic logic [15:0] rst_val(input int ix);
    if (ix == IX_DSP_CTL) return 16'h0080;
    if (ix == IX_SND_BIA) return 16'h0200;
    return 16'h0000;
  endfunction

endpackage

// File: rtl/io_bank_shaper.sv
module io_bank_shaper
  import io_bank_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic                 wr_en,
  input  logic [1:0]           wr_size,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [31:0]          wr_data,
  input  logic [16*(1<<(ADDR_W-1))-1:0] store_flat,
  output logic                 we_a,
  output logic [ADDR_W-2:0]    ix_a,
  output logic [15:0]          d_a,
  output logic                 we_b,
  output logic [ADDR_W-2:0]    ix_b,
  output logic [15:0]          d_b,
  output logic                 now_v,
  output logic [ADDR_W-2:0]    now_ix,
  output logic [31:0]          now_val,
  output logic                 now_wide,
  output logic                 late_v,
  output logic [ADDR_W-2:0]    late_ix,
  output logic [31:0]          late_val,
  output logic                 halt_n,
  output logic                 stop_n
);
  localparam int IW   = ADDR_W - 1;
  localparam int NREG = 1 << IW;

  logic [15:0] st [NREG];
  logic [IW-1:0] ix0, ix1;
  logic [15:0] h0, h1;
  logic g0, g1;

  always_comb begin
    for (int i = 0; i < NREG; i++) st[i] = store_flat[i*16 +: 16];
  end

  function automatic logic [15:0] apply(input int ix, input logic [15:0] v,
                                        input logic [15:0] old);
    if (ix == IX_IRQ_FLG) return old & ~v;
    return v & wmask(ix);
  endfunction

  // access decode: lane merge, word split, halt byte
  always_comb begin
    ix0    = wr_addr[ADDR_W-1:1];
    ix1    = ix0;
    h0     = wr_data[15:0];
    h1     = wr_data[31:16];
    g0     = 1'b0;
    g1     = 1'b0;
    halt_n = 1'b0;
    stop_n = 1'b0;
    if (wr_en) begin
      case (wr_size)
        SZ_BYTE: begin
          if (int'(wr_addr) == HALT_BYTE) begin
            halt_n = ~wr_data[7];
            stop_n = wr_data[7];
          end else begin
            g0 = 1'b1;
            h0 = wr_addr[0] ? {wr_data[7:0], st[ix0][7:0]}
                            : {st[ix0][15:8], wr_data[7:0]};
          end
        end
        SZ_HALF: g0 = 1'b1;
        SZ_WORD: begin
          ix0 = {wr_addr[ADDR_W-1:2], 1'b0};
          ix1 = {wr_addr[ADDR_W-1:2], 1'b1};
          g0  = 1'b1;
          g1  = 1'b1;
        end
        default: ;
      endcase
    end
  end

  // per-register semantics and commit formation
  always_comb begin
    we_a = 1'b0; ix_a = ix0; d_a = 16'h0;
    we_b = 1'b0; ix_b = ix1; d_b = 16'h0;
    now_v = 1'b0; now_ix = ix0; now_val = 32'h0; now_wide = 1'b0;
    late_v = 1'b0; late_ix = ix1; late_val = 32'h0;
    if (g0 && is_pair(int'(ix0))) begin
      ix_a = {ix0[IW-1:1], 1'b0};
      ix_b = {ix0[IW-1:1], 1'b1};
      d_a  = g1 ? h0 : (ix0[0] ? st[ix_a] : h0);
      d_b  = g1 ? h1 : (ix0[0] ? h0 : st[ix_b]);
      we_a = 1'b1;
      we_b = 1'b1;
      now_v    = 1'b1;
      now_ix   = ix_a;
      now_val  = {d_b, d_a};
      now_wide = 1'b1;
    end else begin
      if (g0 && wr_ok(int'(ix0))) begin
        we_a    = 1'b1;
        d_a     = apply(int'(ix0), h0, st[ix0]);
        now_v   = 1'b1;
        now_val = {16'h0, d_a};
      end
      if (g1 && wr_ok(int'(ix1))) begin
        we_b     = 1'b1;
        d_b      = apply(int'(ix1), h1, st[ix1]);
        late_v   = 1'b1;
        late_val = {16'h0, d_b};
      end
    end
  end

endmodule

// File: rtl/io_bank_store.sv
module io_bank_store
  import io_bank_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we_a,
  input  logic [ADDR_W-2:0]    ix_a,
  input  logic [15:0]          d_a,
  input  logic                 we_b,
  input  logic [ADDR_W-2:0]    ix_b,
  input  logic [15:0]          d_b,
  input  logic [15:0]          flag_set,
  output logic [16*(1<<(ADDR_W-1))-1:0] store_flat
);
  localparam int NREG = 1 << (ADDR_W - 1);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [15:0] q, nxt;
    always_comb begin
      nxt = q;
      if (we_a && int'(ix_a) == i) nxt = d_a;
      if (we_b && int'(ix_b) == i) nxt = d_b;
      if (i == IX_IRQ_FLG) nxt = nxt | flag_set;
    end
    always_ff @(posedge clk) begin
      if (rst) q <= rst_val(i);
      else     q <= nxt;
    end
    assign store_flat[i*16 +: 16] = q;
  end

endmodule

// File: rtl/io_bank.sv
module io_bank
  import io_bank_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int KEY_W  = KEY_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_size,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-2:0] rd_idx,
  output logic [15:0]       rd_data,
  input  logic [KEY_W-1:0]  keys,
  input  logic [15:0]       irq_raise,
  output logic              commit_o,
  output logic [ADDR_W-2:0] commit_idx,
  output logic [31:0]       commit_val,
  output logic              commit_wide,
  output logic              halt_o,
  output logic              stop_o
);
  localparam int IW   = ADDR_W - 1;
  localparam int NREG = 1 << IW;
  localparam logic [15:0] KEY_ALL = 16'((1 << KEY_W) - 1);

  logic [16*NREG-1:0] store_flat;
  logic we_a, we_b, now_v, now_wide, late_v, halt_n, stop_n;
  logic [IW-1:0] ix_a, ix_b, now_ix, late_ix;
  logic [15:0] d_a, d_b;
  logic [31:0] now_val, late_val;

  logic          pend_v;
  logic [IW-1:0] pend_ix;
  logic [31:0]   pend_val;
  logic [15:0]   rd_next;

  io_bank_shaper #(.ADDR_W(ADDR_W)) u_shape (
    .wr_en(wr_en), .wr_size(wr_size), .wr_addr(wr_addr), .wr_data(wr_data),
    .store_flat(store_flat),
    .we_a(we_a), .ix_a(ix_a), .d_a(d_a), .we_b(we_b), .ix_b(ix_b), .d_b(d_b),
    .now_v(now_v), .now_ix(now_ix), .now_val(now_val), .now_wide(now_wide),
    .late_v(late_v), .late_ix(late_ix), .late_val(late_val),
    .halt_n(halt_n), .stop_n(stop_n)
  );

  io_bank_store #(.ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst(rst),
    .we_a(we_a), .ix_a(ix_a), .d_a(d_a), .we_b(we_b), .ix_b(ix_b), .d_b(d_b),
    .flag_set(irq_raise), .store_flat(store_flat)
  );

  always_comb begin
    if (int'(rd_idx) == IX_KEYS)
      rd_next = KEY_ALL ^ 16'(keys);
    else if (rd_ok(int'(rd_idx)))
      rd_next = store_flat[{rd_idx, 4'b0000} +: 16];
    else
      rd_next = 16'h0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data     <= 16'h0;
      commit_o    <= 1'b0;
      commit_idx  <= '0;
      commit_val  <= 32'h0;
      commit_wide <= 1'b0;
      pend_v      <= 1'b0;
      pend_ix     <= '0;
      pend_val    <= 32'h0;
      halt_o      <= 1'b0;
      stop_o      <= 1'b0;
    end else begin
      rd_data  <= rd_next;
      pend_v   <= late_v;
      pend_ix  <= late_ix;
      pend_val <= late_val;
      commit_o <= now_v | pend_v;
      if (now_v) begin
        commit_idx  <= now_ix;
        commit_val  <= now_val;
        commit_wide <= now_wide;
      end else if (pend_v) begin
        commit_idx  <= pend_ix;
        commit_val  <= pend_val;
        commit_wide <= 1'b0;
      end
      halt_o <= halt_n;
      stop_o <= stop_n;
    end
  end

endmodule

// File: rtl/io_bank_chk.sv
module io_bank_chk
  import io_bank_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int KEY_W  = KEY_BITS
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [1:0]        wr_size,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              wr_b7,
  input logic [ADDR_W-2:0] rd_idx,
  input logic [15:0]       rd_data,
  input logic [KEY_W-1:0]  keys,
  input logic              commit_o,
  input logic [ADDR_W-2:0] commit_idx,
  input logic [31:0]       commit_val,
  input logic              commit_wide,
  input logic              halt_o,
  input logic              stop_o
);
  localparam logic [15:0] KEY_ALL = 16'((1 << KEY_W) - 1);

  p_halt_src_r10: assert property (@(posedge clk) disable iff (rst)
    halt_o |-> $past(wr_en && wr_size == SZ_BYTE && int'(wr_addr) == HALT_BYTE && !wr_b7));

  p_stop_src_r10: assert property (@(posedge clk) disable iff (rst)
    stop_o |-> $past(wr_en && wr_size == SZ_BYTE && int'(wr_addr) == HALT_BYTE && wr_b7));

  p_wo_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (int'(rd_idx) == IX_XFR_LEN) |=> (rd_data == 16'h0));

  p_key_read_r9: assert property (@(posedge clk) disable iff (rst)
    (int'(rd_idx) == IX_KEYS) |=> (rd_data == (KEY_ALL ^ 16'($past(keys)))));

  p_tmr_mask_r4: assert property (@(posedge clk) disable iff (rst)
    (commit_o && !commit_wide && is_tmr(int'(commit_idx))) |-> ((commit_val & ~32'h00C7) == 32'h0));

  p_commit_src_r2: assert property (@(posedge clk) disable iff (rst)
    commit_o |-> ($past(wr_en) || $past(wr_en, 2)));

  p_wide_pair_r7: assert property (@(posedge clk) disable iff (rst)
    (commit_o && commit_wide) |-> (is_pair(int'(commit_idx)) && !commit_idx[0]));

  p_word_gap_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_size == SZ_WORD) |=> !wr_en);

endmodule

bind io_bank io_bank_chk #(.ADDR_W(ADDR_W), .KEY_W(KEY_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_size(wr_size), .wr_addr(wr_addr),
  .wr_b7(wr_data[7]), .rd_idx(rd_idx), .rd_data(rd_data), .keys(keys),
  .commit_o(commit_o), .commit_idx(commit_idx), .commit_val(commit_val),
  .commit_wide(commit_wide), .halt_o(halt_o), .stop_o(stop_o)
);

// File: tb/sim_io_bank.sv
module sim_io_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_size = 2'd3;
  logic [6:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [5:0]  rd_idx = '0;
  logic [15:0] rd_data;
  logic [9:0]  keys = '0;
  logic [15:0] irq_raise = '0;
  logic        commit_o, commit_wide, halt_o, stop_o;
  logic [5:0]  commit_idx;
  logic [31:0] commit_val;

  always #(CLK_PERIOD/2) clk = ~clk;

  io_bank u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_size(wr_size), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data), .keys(keys),
    .irq_raise(irq_raise), .commit_o(commit_o), .commit_idx(commit_idx),
    .commit_val(commit_val), .commit_wide(commit_wide), .halt_o(halt_o), .stop_o(stop_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [15:0] m [64];

  // expected output events, keyed by cycle number
  int          q_t[$];
  int          q_ix[$];
  logic [31:0] q_v[$];
  int          q_f[$];   // bit0 commit, bit1 wide, bit2 halt, bit3 stop
  string       q_r[$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [15:0] bmask(input int ix);
    if (ix == 1) return 16'hFFF8;
    if (ix >= 12 && ix <= 15) return 16'h00C7;
    if (ix == 16) return 16'hC1FF;
    return 16'hFFFF;
  endfunction

  function automatic bit bwr(input int ix);
    return ix == 0 || ix == 1 || ix == 2 || (ix >= 4 && ix <= 9) ||
           (ix >= 12 && ix <= 16) || (ix >= 24 && ix <= 26);
  endfunction

  function automatic bit bpair(input int ix);
    return ix >= 4 && ix <= 7;
  endfunction

  function automatic logic [15:0] bread(input int ix);
    if (ix == 20) return 16'h03FF ^ {6'h0, keys};
    if (ix == 8 || !bwr(ix)) return 16'h0;
    return m[ix];
  endfunction

  task automatic push(input int t, input int ix, input logic [31:0] v, input int f, input string r);
    q_t.push_back(t); q_ix.push_back(ix); q_v.push_back(v); q_f.push_back(f); q_r.push_back(r);
  endtask

  task automatic half_op(input int ix, input logic [15:0] h, input int t, input string r);
    int lo;
    logic [15:0] a, b, nv;
    if (bpair(ix)) begin
      lo = ix & ~1;
      a = (ix % 2 == 1) ? m[lo] : h;
      b = (ix % 2 == 1) ? h : m[lo+1];
      m[lo] = a; m[lo+1] = b;
      push(t, lo, {b, a}, 3, r);
    end else if (bwr(ix)) begin
      nv = (ix == 25) ? (m[ix] & ~h) : (h & bmask(ix));
      m[ix] = nv;
      push(t, ix, {16'h0, nv}, 1, r);
    end
  endtask

  task automatic wr(input logic [1:0] sz, input logic [6:0] a, input logic [31:0] d, input string r);
    int ix;
    logic [15:0] h;
    @(negedge clk);
    wr_en = 1'b1; wr_size = sz; wr_addr = a; wr_data = d;
    if (sz == 2'd0) begin
      if (a == 7'd61) push(cyc + 1, 0, 32'h0, d[7] ? 8 : 4, r);
      else begin
        ix = int'(a) >> 1;
        h = a[0] ? {d[7:0], m[ix][7:0]} : {m[ix][15:8], d[7:0]};
        half_op(ix, h, cyc + 1, r);
      end
    end else if (sz == 2'd1) begin
      half_op(int'(a) >> 1, d[15:0], cyc + 1, r);
    end else if (sz == 2'd2) begin
      ix = (int'(a) >> 2) * 2;
      if (bpair(ix)) begin
        m[ix] = d[15:0]; m[ix+1] = d[31:16];
        push(cyc + 1, ix, d, 3, r);
      end else begin
        half_op(ix, d[15:0], cyc + 1, r);
        half_op(ix + 1, d[31:16], cyc + 2, r);
      end
    end
    @(negedge clk);
    wr_en = 1'b0;
    if (sz == 2'd2) @(negedge clk);
  endtask

  task automatic rd(input int ix, input string r);
    logic [15:0] e;
    @(negedge clk);
    rd_idx = 6'(ix);
    e = bread(ix);
    @(negedge clk);
    chk(rd_data === e, r, {48'h0, rd_data}, {48'h0, e});
  endtask

  task automatic raise(input logic [15:0] v);
    @(negedge clk);
    irq_raise = v;
    m[25] = m[25] | v;
    @(negedge clk);
    irq_raise = '0;
  endtask

  // R5: a raise and a clear of the same flag in one cycle
  task automatic raise_and_clear(input logic [15:0] set, input logic [15:0] clr);
    logic [15:0] nv;
    @(negedge clk);
    irq_raise = set; wr_en = 1'b1; wr_size = 2'd1; wr_addr = 7'd50; wr_data = {16'h0, clr};
    nv = m[25] & ~clr;
    push(cyc + 1, 25, {16'h0, nv}, 1, "R5");
    m[25] = nv | set;
    @(negedge clk);
    wr_en = 1'b0; irq_raise = '0;
  endtask

  // per-clock comparison of the event outputs against the model
  int          e_ix, e_f;
  logic [31:0] e_v;
  string       e_r;
  bit          e_ok;
  always @(posedge clk) begin
    #1;
    cyc = cyc + 1;
    if (!rst) begin
      e_ix = 0; e_v = 32'h0; e_f = 0; e_r = "R2";
      if (q_t.size() > 0 && q_t[0] == cyc) begin
        e_ix = q_ix.pop_front(); e_v = q_v.pop_front(); e_f = q_f.pop_front();
        e_r = q_r.pop_front(); void'(q_t.pop_front());
      end
      e_ok = (commit_o == e_f[0]) && (halt_o == e_f[2]) && (stop_o == e_f[3]) &&
             (!e_f[0] || (int'(commit_idx) == e_ix && commit_val == e_v && commit_wide == e_f[1]));
      chk(e_ok, e_r,
          {19'h0, stop_o, halt_o, commit_wide, commit_o, 1'b0, commit_idx, commit_val},
          {19'h0, e_f[3], e_f[2], e_f[1], e_f[0], 1'b0, 6'(e_ix), e_v});
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) m[i] = 16'h0;
    m[0] = 16'h0080; m[2] = 16'h0200;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    rd(0, "R1"); rd(2, "R1"); rd(1, "R1"); rd(25, "R1");
    rd(20, "R9");

    wr(2'd1, 7'd0, 32'h0000_BEEF, "R2");  rd(0, "R2");
    wr(2'd0, 7'd1, 32'h0000_0012, "R3");  rd(0, "R3");
    wr(2'd0, 7'd0, 32'h0000_0034, "R3");  rd(0, "R3");

    wr(2'd1, 7'd2, 32'h0000_FFFF, "R4");  rd(1, "R4");
    wr(2'd1, 7'd24, 32'h0000_FFFF, "R4"); rd(12, "R4");
    wr(2'd0, 7'd27, 32'h0000_00FF, "R4"); rd(13, "R4");
    wr(2'd1, 7'd32, 32'h0000_FFFF, "R4"); rd(16, "R4");

    wr(2'd2, 7'd28, 32'hFFFF_1234, "R8"); rd(14, "R8"); rd(15, "R8");
    wr(2'd2, 7'd48, 32'h0003_00F0, "R8"); rd(24, "R8");

    wr(2'd1, 7'd8, 32'h0000_AAAA, "R7");  rd(4, "R7");
    wr(2'd1, 7'd10, 32'h0000_5555, "R7"); rd(5, "R7");
    wr(2'd0, 7'd11, 32'h0000_0077, "R7"); rd(5, "R7");
    wr(2'd2, 7'd12, 32'hDEAD_BEEF, "R7"); rd(6, "R7"); rd(7, "R7");

    wr(2'd1, 7'd16, 32'h0000_1234, "R6"); rd(8, "R6");

    raise(16'h00F3);                      rd(25, "R5");
    wr(2'd1, 7'd50, 32'h0000_0031, "R5"); rd(25, "R5");
    raise_and_clear(16'h0002, 16'h0082); rd(25, "R5");

    keys = 10'h155;                       rd(20, "R9");
    keys = 10'h3C1;                       rd(20, "R9");
    wr(2'd1, 7'd40, 32'h0000_0000, "R9"); rd(20, "R9");

    wr(2'd1, 7'd6, 32'h0000_FFFF, "R11"); rd(3, "R11");
    wr(2'd2, 7'd20, 32'hFFFF_FFFF, "R11"); rd(10, "R11"); rd(11, "R11");

    wr(2'd0, 7'd61, 32'h0000_0000, "R10");
    wr(2'd0, 7'd61, 32'h0000_0080, "R10");
    rd(30, "R10"); rd(0, "R10");

    repeat (4) @(negedge clk);
    chk(q_t.size() == 0, "R2", 64'(q_t.size()), 64'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule